// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block turns parallel characters into an asynchronous serial stream. A one-character data register sits in front of a shift register, so software can queue the next character while the current one is still on the line. Frames carry eight data bits, or nine when the wide-character mode is selected. The extra bit is taken from a separate input at the moment the character is written.

Two status flags report progress. One flag says that the data register is empty. The other says that the line has fallen silent with nothing left to send. Each flag drives an interrupt request, which is qualified by its own enable and by a global enable. Bit timing comes from an external baud tick, one tick per bit time.

Dropping the transmitter enable is graceful. The character already being shifted out, and any character waiting in the data register, are both sent in full before the line goes idle.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset, `txd` is 1, `dre_flag` is 1, `tc_flag` is 0, and both interrupt outputs are 0.
- R2: With `nine_bit_mode` = 0, a frame is 10 bit times long: a start bit of 0, then `wr_data` bit 0 first through bit 7, then a stop bit of 1. `txd` changes only on a clock edge where `baud_tick` is 1.
- R3: With `nine_bit_mode` = 1 at the moment of loading, the frame is 11 bit times long. The ninth bit is sent after data bit 7 and before the stop bit, and it equals the `bit9_in` value captured with the write.
- R4: A write (`wr_en` = 1) clears `dre_flag` on the next cycle. Loading takes place on the first edge with `baud_tick` = 1 where three conditions hold: the shift register is idle or ending its stop bit, the data register is full, and sending is allowed. On that edge `dre_flag` sets and `txd` shows the start bit.
- R5: A character that is waiting when a stop bit ends starts on that same tick, with no idle bit time between the two frames.
- R6: `tc_flag` sets on the tick that ends a stop bit when no character is waiting. A write clears it, and a write wins over a set in the same cycle.
- R7: `dre_irq` equals `gie & dre_ie & dre_flag`, and `tc_irq` equals `gie & tc_ie & tc_flag`.
- R8: When `tx_enable` falls during a frame, the current frame and any waiting character are both sent completely. After that the line stays high.
- R9: While `tx_enable` is 0 and nothing is draining, a written character stays in the data register and `txd` stays 1. The character is sent once `tx_enable` returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle pulse per bit time |
| wr_en | input | 1 | Write strobe for the data register |
| wr_data | input | 8 | Character to queue |
| bit9_in | input | 1 | Ninth data bit, captured with the write |
| nine_bit_mode | input | 1 | 1 selects 9-bit characters |
| tx_enable | input | 1 | Transmitter enable |
| gie | input | 1 | Global interrupt enable |
| dre_ie | input | 1 | Data-register-empty interrupt enable |
| tc_ie | input | 1 | Transmit-complete interrupt enable |
| txd | output | 1 | Serial line, idles high |
| dre_flag | output | 1 | Data register empty |
| tc_flag | output | 1 | Transmission complete |
| dre_irq | output | 1 | Data-register-empty interrupt request |
| tc_irq | output | 1 | Transmit-complete interrupt request |

## Verification
The main serial function is tried with alternating bits (0x55), mixed bits (0xA3), all zeros and all ones in 8-bit mode. The all-zeros and all-ones characters separate a missing or misplaced start or stop bit from real data bits, and the alternating and mixed patterns expose bit order and off-by-one shifting. In 9-bit mode the ninth bit is tried at both 0 and 1, including with an all-zero data byte, which shows whether it is sent in the right slot, is taken from the captured input, and is not confused with the stop bit. Separate sequences cover a back-to-back pair sent across a falling enable, and a character held back while the transmitter is disabled.

// File: rtl/utx_pkg.sv
package utx_pkg;
    localparam int unsigned CHAR_W    = 8;
    localparam int unsigned FRAME_MAX = CHAR_W + 3;
    localparam int unsigned CNT_W     = $clog2(FRAME_MAX + 1);

    typedef struct packed {
        logic [CHAR_W-1:0] data;
        logic              bit9;
    } tx_char_t;

    typedef enum logic {SH_IDLE = 1'b0, SH_BUSY = 1'b1} sh_state_e;

    function automatic logic [FRAME_MAX-1:0] build_frame(tx_char_t c, logic nine);
        return {1'b1, (nine ? c.bit9 : 1'b1), c.data, 1'b0};
    endfunction

    function automatic logic [CNT_W-1:0] frame_len(logic nine);
        return nine ? CNT_W'(FRAME_MAX) : CNT_W'(FRAME_MAX - 1);
    endfunction
endpackage

// File: rtl/utx_holding.sv
module utx_holding
    import utx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_en,
    input  tx_char_t wr_char,
    input  logic     take,
    output tx_char_t held,
    output logic     full
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
            full <= 1'b0;
        end else if (wr_en) begin
            held <= wr_char;
            full <= 1'b1;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    // R4: a write always leaves the register occupied
    assert_write_fills_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> full);
    // R4: a load without a fresh write empties it
    assert_take_empties_R4: assert property (@(posedge clk) disable iff (rst)
        (take && !wr_en) |=> !full);
endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
    import utx_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     baud_tick,
    input  logic     can_load,
    input  tx_char_t in_char,
    input  logic     nine_bit,
    output logic     load,
    output logic     busy,
    output logic     frame_done,
    output logic     txd
);
    sh_state_e            state;
    logic [FRAME_MAX-1:0] shreg;
    logic [CNT_W-1:0]     bits_left;
    logic                 last_tick;

    assign busy       = (state == SH_BUSY);
    assign last_tick  = busy && baud_tick && (bits_left == CNT_W'(1));
    assign load       = baud_tick && (!busy || last_tick) && can_load;
    assign frame_done = last_tick;
    assign txd        = busy ? shreg[0] : 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SH_IDLE;
            shreg     <= '1;
            bits_left <= '0;
        end else if (load) begin
            state     <= SH_BUSY;
            shreg     <= build_frame(in_char, nine_bit);
            bits_left <= frame_len(nine_bit);
        end else if (last_tick) begin
            state     <= SH_IDLE;
        end else if (busy && baud_tick) begin
            shreg     <= {1'b1, shreg[FRAME_MAX-1:1]};
            bits_left <= bits_left - CNT_W'(1);
        end
    end

    // R4: the start bit appears on the edge that loads
    assert_start_low_R4: assert property (@(posedge clk) disable iff (rst)
        load |=> !txd);
    // R2: the line only moves on a baud tick
    assert_hold_between_ticks_R2: assert property (@(posedge clk) disable iff (rst)
        !baud_tick |=> $stable(txd));
    // R3: the bit counter never exceeds the longest frame
    assert_count_range_R3: assert property (@(posedge clk) disable iff (rst)
        bits_left <= CNT_W'(FRAME_MAX));
endmodule

// File: rtl/utx_status.sv
module utx_status (
    input  logic clk,
    input  logic rst,
    input  logic frame_done,
    input  logic load,
    input  logic wr_en,
    input  logic full,
    input  logic gie,
    input  logic dre_ie,
    input  logic tc_ie,
    output logic tc_flag,
    output logic dre_irq,
    output logic tc_irq
);
    always_ff @(posedge clk) begin
        if (rst)                      tc_flag <= 1'b0;
        else if (wr_en)               tc_flag <= 1'b0;
        else if (frame_done && !load) tc_flag <= 1'b1;
    end

    assign dre_irq = gie & dre_ie & !full;
    assign tc_irq  = gie & tc_ie & tc_flag;

    // R6: completion is only reported with nothing waiting
    assert_tc_empty_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(tc_flag) |-> !full);
    // R6: completion follows the end of a stop bit
    assert_tc_after_stop_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(tc_flag) |-> $past(frame_done));
endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf
    import utx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick,
    input  logic              wr_en,
    input  logic [CHAR_W-1:0] wr_data,
    input  logic              bit9_in,
    input  logic              nine_bit_mode,
    input  logic              tx_enable,
    input  logic              gie,
    input  logic              dre_ie,
    input  logic              tc_ie,
    output logic              txd,
    output logic              dre_flag,
    output logic              tc_flag,
    output logic              dre_irq,
    output logic              tc_irq
);
    tx_char_t wr_char, held;
    logic     full, load, busy, frame_done, run_q, allow;

    assign wr_char = '{data: wr_data, bit9: bit9_in};
    assign allow   = tx_enable | run_q;

    // keeps sending after the enable falls until nothing is left
    always_ff @(posedge clk) begin
        if (rst) run_q <= 1'b0;
        else     run_q <= tx_enable | (run_q & (busy | full));
    end

    utx_holding u_hold (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_char(wr_char),
        .take(load), .held(held), .full(full)
    );

    utx_shifter u_shift (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .can_load(full & allow),
        .in_char(held), .nine_bit(nine_bit_mode), .load(load), .busy(busy),
        .frame_done(frame_done), .txd(txd)
    );

    utx_status u_stat (
        .clk(clk), .rst(rst), .frame_done(frame_done), .load(load),
        .wr_en(wr_en), .full(full), .gie(gie), .dre_ie(dre_ie), .tc_ie(tc_ie),
        .tc_flag(tc_flag), .dre_irq(dre_irq), .tc_irq(tc_irq)
    );

    assign dre_flag = !full;

    // R8: a falling enable keeps the drain alive
    assert_drain_on_fall_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_enable) |-> run_q);
    // R9: nothing starts while disabled and drained
    assert_no_start_disabled_R9: assert property (@(posedge clk) disable iff (rst)
        (!allow && !busy) |=> !busy);
endmodule

// File: tb/uart_tx_dbuf_test.sv
`timescale 1ns/1ps
module uart_tx_dbuf_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic baud_tick = 1'b0, wr_en = 1'b0, bit9_in = 1'b0, nine_bit_mode = 1'b0;
    logic tx_enable = 1'b0, gie = 1'b0, dre_ie = 1'b0, tc_ie = 1'b0;
    logic [7:0] wr_data = '0;
    logic txd, dre_flag, tc_flag, dre_irq, tc_irq;

    int n_checks = 0, n_fail = 0;
    logic [10:0] cap;
    bit done = 0;

    localparam int TICK_DIV = 4;
    // {nine_bit_mode, bit9_in, data}
    localparam logic [9:0] VEC [7] = '{
        {2'b00, 8'h55}, {2'b00, 8'hA3}, {2'b00, 8'h00}, {2'b00, 8'hFF},
        {2'b11, 8'h3C}, {2'b10, 8'hC1}, {2'b11, 8'h00}
    };

    always #2.5 clk = ~clk;

    uart_tx_dbuf uut (
        .clk(clk), .rst(rst), .baud_tick(baud_tick), .wr_en(wr_en),
        .wr_data(wr_data), .bit9_in(bit9_in), .nine_bit_mode(nine_bit_mode),
        .tx_enable(tx_enable), .gie(gie), .dre_ie(dre_ie), .tc_ie(tc_ie),
        .txd(txd), .dre_flag(dre_flag), .tc_flag(tc_flag),
        .dre_irq(dre_irq), .tc_irq(tc_irq)
    );

    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            baud_tick = (cnt == TICK_DIV - 1);
            cnt = (cnt + 1) % TICK_DIV;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_char(logic [7:0] d, logic b9);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; bit9_in = b9;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_start(string req);
        for (int i = 0; i < 200; i++) begin
            if (txd === 1'b0) return;
            @(negedge clk);
        end
        check(req, 32'(txd), 32'h0);
    endtask

    // samples bits lo..hi, one bit time apart; the caller stands on bit lo-1
    task automatic sample_bits(int lo, int hi);
        for (int k = lo; k <= hi; k++) begin
            repeat (TICK_DIV) @(negedge clk);
            cap[k] = txd;
        end
    endtask

    function automatic logic [10:0] exp_frame(logic [7:0] d, logic b9, logic m9);
        return {1'b1, (m9 ? b9 : 1'b1), d, 1'b0};
    endfunction

    function automatic logic [10:0] fmask(logic m9);
        return m9 ? 11'h7FF : 11'h3FF;
    endfunction

    initial begin
        repeat (6) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 txd", 32'(txd), 1);
        check("R1 dre_flag", 32'(dre_flag), 1);
        check("R1 tc_flag", 32'(tc_flag), 0);
        check("R1 irqs", 32'({dre_irq, tc_irq}), 0);

        // R7: data-register-empty interrupt gating
        gie = 1'b1; dre_ie = 1'b0; #0.1;
        check("R7 dre_irq ie=0", 32'(dre_irq), 0);
        gie = 1'b0; dre_ie = 1'b1; #0.1;
        check("R7 dre_irq gie=0", 32'(dre_irq), 0);
        gie = 1'b1; #0.1;
        check("R7 dre_irq on", 32'(dre_irq), 1);
        dre_ie = 1'b0;

        // vector table: R2, R3, R4, R6
        tx_enable = 1'b1;
        for (int v = 0; v < 7; v++) begin
            logic m9, b9;
            logic [7:0] d;
            int n;
            m9 = VEC[v][9]; b9 = VEC[v][8]; d = VEC[v][7:0];
            n = m9 ? 11 : 10;
            nine_bit_mode = m9;
            write_char(d, b9);
            check("R4 dre cleared by write", 32'(dre_flag), 0);
            check("R6 tc cleared by write", 32'(tc_flag), 0);
            wait_start("R4 start bit");
            check("R4 dre set at load", 32'(dre_flag), 1);
            cap = '0;
            cap[0] = txd;
            sample_bits(1, n - 1);
            check(m9 ? "R3 nine-bit frame" : "R2 eight-bit frame",
                  32'(cap & fmask(m9)), 32'(exp_frame(d, b9, m9) & fmask(m9)));
            check("R6 tc clear during stop", 32'(tc_flag), 0);
            repeat (TICK_DIV) @(negedge clk);
            check("R6 tc set after stop", 32'(tc_flag), 1);
            check("R2 line idle high", 32'(txd), 1);
        end

        // R7: transmit-complete interrupt gating
        tc_ie = 1'b1; gie = 1'b0; #0.1;
        check("R7 tc_irq gie=0", 32'(tc_irq), 0);
        gie = 1'b1; #0.1;
        check("R7 tc_irq on", 32'(tc_irq), 1);
        tc_ie = 1'b0; #0.1;
        check("R7 tc_irq ie=0", 32'(tc_irq), 0);

        // R8 and R5: drain across a falling enable, back-to-back
        nine_bit_mode = 1'b0;
        write_char(8'h96, 1'b0);
        wait_start("R8 first start");
        cap = '0;
        cap[0] = txd;
        wr_en = 1'b1; wr_data = 8'h3A; tx_enable = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        repeat (TICK_DIV - 1) @(negedge clk);
        cap[1] = txd;
        sample_bits(2, 9);
        check("R8 first frame drained", 32'(cap & 11'h3FF), 32'(exp_frame(8'h96, 1'b0, 1'b0) & 11'h3FF));
        check("R6 tc clear with char waiting", 32'(tc_flag), 0);
        repeat (TICK_DIV) @(negedge clk);
        check("R5 no gap before second start", 32'(txd), 0);
        cap = '0;
        cap[0] = txd;
        sample_bits(1, 9);
        check("R8 second frame drained", 32'(cap & 11'h3FF), 32'(exp_frame(8'h3A, 1'b0, 1'b0) & 11'h3FF));
        repeat (TICK_DIV) @(negedge clk);
        check("R8 tc after drain", 32'(tc_flag), 1);
        begin
            int lows = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (txd !== 1'b1) lows++;
            end
            check("R8 line high after drain", 32'(lows), 0);
        end

        // R9: character held while disabled
        write_char(8'h5C, 1'b0);
        begin
            int lows = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (txd !== 1'b1) lows++;
            end
            check("R9 line high while disabled", 32'(lows), 0);
        end
        check("R9 char still waiting", 32'(dre_flag), 0);
        tx_enable = 1'b1;
        wait_start("R9 start after enable");
        cap = '0;
        cap[0] = txd;
        sample_bits(1, 9);
        check("R9 held frame sent", 32'(cap & 11'h3FF), 32'(exp_frame(8'h5C, 1'b0, 1'b0) & 11'h3FF));

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule